// File: doc/BRIEF.md
# USB Low-Speed Packet Transmitter

This block puts one packet on the D+/D- pair of a low-speed USB device. A single-cycle start strobe arrives with a byte count. The block then takes the bus: it turns on the line drivers with the idle J state and waits for the first bit-rate enable. It next sends the synchronisation byte, followed by the requested number of bytes. It fetches these through a combinational read port, starting at address zero. Each bit goes through NRZI encoding. A stuffed bit is inserted wherever the data would otherwise hold the line for too long.

After the last data bit, and after any stuffed bit that bit requires, the block closes the packet. It drives both lines low for two bit times, then J for one bit time, and then turns the drivers off. It marks the release with a one-cycle done pulse. Bit timing comes from `bit_en_i`, which is high for one clock cycle per bit time. The line outputs change only on those cycles, so the block can run from any clock faster than the bit rate. The byte count covers every byte after the sync byte, PID included. A handshake reply is therefore a count of one.

Top module: `lsx_pkt_tx`

## Requirements
- R1: A start strobe accepted while idle makes `oe_o` high with the line in J (`dp_o`=0, `dm_o`=1) and `busy_o` high on the next cycle. The line holds J until the first bit-enable cycle.
- R2: The first byte on the wire is the sync pattern 0x80. The `nbytes_i` buffer bytes follow it, read from addresses 0 upward. Every byte goes out least significant bit first, so the count includes the PID and a one-byte handshake uses count 1.
- R3: NRZI encoding takes J as its starting reference. A 0 bit swaps J and K (K is `dp_o`=1, `dm_o`=0), and a 1 bit leaves the line unchanged. The line is never driven with both outputs high.
- R4: Once six 1 bits have been sent in a row, an extra toggle is inserted and the run count restarts. The count spans byte boundaries and includes the last bit of the sync byte. Any 0 bit or inserted toggle resets it, and the rule also applies after the final data bit.
- R5: After the last bit and any stuffed bit, both lines are driven low for exactly two bit times with `oe_o` high.
- R6: J is then driven for one bit time, and `oe_o` falls on the next bit-enable cycle. `oe_o` is high exactly while `busy_o` is high.
- R7: `done_o` is high for a single cycle: the first cycle in which `oe_o` is low after a packet. `busy_o` is low in that cycle.
- R8: While busy, `dp_o`, `dm_o` and `oe_o` change only in the cycle after one in which `bit_en_i` was high.
- R9: A start strobe, or any change of `nbytes_i`, while busy has no effect on the packet in flight.
- R10: During and after reset, `oe_o`, `busy_o` and `done_o` are low, and the line holds the J levels.
- R11: A byte count of zero sends the sync byte alone, followed by the normal end sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, honoured only when idle |
| nbytes_i | input | LEN_W | Number of buffer bytes to send (PID included) |
| rd_addr_o | output | LEN_W | Buffer read address |
| rd_data_i | input | 8 | Buffer byte at `rd_addr_o`, valid in the same cycle |
| bit_en_i | input | 1 | One-cycle pulse per bit time |
| dp_o | output | 1 | D+ level |
| dm_o | output | 1 | D- level |
| oe_o | output | 1 | Line driver enable |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle pulse when the bus is released |

## Verification
The bus takeover is due one cycle after the start strobe, so it is checked at the falling edge that follows the accepting clock edge. Every other result shows up one register after a `bit_en_i` cycle. The bench therefore samples the line at the falling edge after each enabled rising edge, and on all other falling edges it checks that nothing moved. From those per-bit samples it decodes NRZI and removes stuffed bits on its own. It then compares the sync byte, the payload, the number of stuffed bits and the SE0/J/release positions against values worked out for each stimulus vector.

// File: rtl/lsx_tx_pkg.sv
package lsx_tx_pkg;

    localparam int BYTE_W  = 8;
    localparam int BIDX_W  = $clog2(BYTE_W);
    localparam logic [BYTE_W-1:0] SYNC_PATTERN = 8'h80;

    // line levels, bit 1 = D+, bit 0 = D-
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_J   = 2'b01,
        LN_K   = 2'b10,
        LN_SE1 = 2'b11
    } line_lvl_e;

    typedef enum logic [1:0] {
        LCMD_HOLD,
        LCMD_J,
        LCMD_TOGGLE,
        LCMD_SE0
    } line_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_SE0A,
        ST_SE0B,
        ST_JEND
    } tx_state_e;

endpackage

// File: rtl/lsx_tx_line.sv
module lsx_tx_line
    import lsx_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  line_cmd_e cmd_i,
    input  logic      oe_set_i,
    input  logic      oe_clr_i,
    output logic      dp_o,
    output logic      dm_o,
    output logic      oe_o
);

    typedef struct packed {
        line_lvl_e lvl;
        logic      oe;
    } line_regs_t;

    line_regs_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        case (cmd_i)
            LCMD_J:      line_d.lvl = LN_J;
            LCMD_TOGGLE: line_d.lvl = (line_q.lvl == LN_J) ? LN_K : LN_J;
            LCMD_SE0:    line_d.lvl = LN_SE0;
            default:     line_d.lvl = line_q.lvl;
        endcase
        if (oe_set_i) begin
            line_d.oe = 1'b1;
        end else if (oe_clr_i) begin
            line_d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '{lvl: LN_J, oe: 1'b0};
        end else begin
            line_q <= line_d;
        end
    end

    assign dp_o = line_q.lvl[1];
    assign dm_o = line_q.lvl[0];
    assign oe_o = line_q.oe;

endmodule

// File: rtl/lsx_tx_stuffer.sv
module lsx_tx_stuffer #(
    parameter int RUN_LIMIT = 6,
    localparam int RUN_W    = $clog2(RUN_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    input  logic             bit_i,
    output logic             stuff_now_o,
    output logic [RUN_W-1:0] run_o
);

    logic [RUN_W-1:0] run_d, run_q;

    assign stuff_now_o = (run_q == RUN_W'(RUN_LIMIT));

    always_comb begin
        run_d = run_q;
        if (clr_i) begin
            run_d = '0;
        end else if (adv_i) begin
            if (stuff_now_o || !bit_i) begin
                run_d = '0;
            end else begin
                run_d = run_q + RUN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    assign run_o = run_q;

endmodule

// File: rtl/lsx_tx_bytefeed.sv
module lsx_tx_bytefeed
    import lsx_tx_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [LEN_W-1:0]  nbytes_i,
    input  logic              shift_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [LEN_W-1:0]  rd_addr_o,
    output logic              bit_o,
    output logic              all_sent_o
);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [BIDX_W-1:0] idx;
        logic [LEN_W-1:0]  addr;
        logic [LEN_W-1:0]  left;
        logic              fin;
    } feed_regs_t;

    feed_regs_t feed_d, feed_q;

    always_comb begin
        feed_d = feed_q;
        if (load_i) begin
            feed_d.sh   = SYNC_PATTERN;
            feed_d.idx  = '0;
            feed_d.addr = '0;
            feed_d.left = nbytes_i;
            feed_d.fin  = 1'b0;
        end else if (shift_i && !feed_q.fin) begin
            if (feed_q.idx == BIDX_W'(BYTE_W - 1)) begin
                if (feed_q.left != '0) begin
                    feed_d.sh   = rd_data_i;
                    feed_d.idx  = '0;
                    feed_d.addr = feed_q.addr + LEN_W'(1);
                    feed_d.left = feed_q.left - LEN_W'(1);
                end else begin
                    feed_d.fin  = 1'b1;
                end
            end else begin
                feed_d.sh  = feed_q.sh >> 1;
                feed_d.idx = feed_q.idx + BIDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            feed_q <= '0;
        end else begin
            feed_q <= feed_d;
        end
    end

    assign rd_addr_o  = feed_q.addr;
    assign bit_o      = feed_q.sh[0];
    assign all_sent_o = feed_q.fin;

endmodule

// File: rtl/lsx_pkt_tx.sv
module lsx_pkt_tx
    import lsx_tx_pkg::*;
#(
    parameter int MAX_BYTES = 11,
    parameter int RUN_LIMIT = 6,
    localparam int LEN_W    = $clog2(MAX_BYTES + 1),
    localparam int RUN_W    = $clog2(RUN_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  nbytes_i,
    output logic [LEN_W-1:0]  rd_addr_o,
    input  logic [BYTE_W-1:0] rd_data_i,
    input  logic              bit_en_i,
    output logic              dp_o,
    output logic              dm_o,
    output logic              oe_o,
    output logic              busy_o,
    output logic              done_o
);

    typedef struct packed {
        tx_state_e st;
        logic      done;
    } ctl_regs_t;

    ctl_regs_t ctl_d, ctl_q;

    line_cmd_e        line_cmd;
    logic             oe_set, oe_clr;
    logic             feed_load, feed_shift, cur_bit, all_sent;
    logic             stuff_clr, stuff_adv, stuff_now;
    logic [RUN_W-1:0] run_cnt;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        line_cmd   = LCMD_HOLD;
        oe_set     = 1'b0;
        oe_clr     = 1'b0;
        feed_load  = 1'b0;
        feed_shift = 1'b0;
        stuff_clr  = 1'b0;
        stuff_adv  = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st  = ST_DATA;
                    line_cmd  = LCMD_J;
                    oe_set    = 1'b1;
                    feed_load = 1'b1;
                    stuff_clr = 1'b1;
                end
            end
            ST_DATA: begin
                if (bit_en_i) begin
                    if (stuff_now) begin
                        line_cmd  = LCMD_TOGGLE;
                        stuff_adv = 1'b1;
                    end else if (all_sent) begin
                        line_cmd = LCMD_SE0;
                        ctl_d.st = ST_SE0A;
                    end else begin
                        line_cmd   = cur_bit ? LCMD_HOLD : LCMD_TOGGLE;
                        feed_shift = 1'b1;
                        stuff_adv  = 1'b1;
                    end
                end
            end
            ST_SE0A: begin
                if (bit_en_i) begin
                    ctl_d.st = ST_SE0B;
                end
            end
            ST_SE0B: begin
                if (bit_en_i) begin
                    line_cmd = LCMD_J;
                    ctl_d.st = ST_JEND;
                end
            end
            ST_JEND: begin
                if (bit_en_i) begin
                    oe_clr     = 1'b1;
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    lsx_tx_bytefeed #(.LEN_W(LEN_W)) u_feed (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (feed_load),
        .nbytes_i   (nbytes_i),
        .shift_i    (feed_shift),
        .rd_data_i  (rd_data_i),
        .rd_addr_o  (rd_addr_o),
        .bit_o      (cur_bit),
        .all_sent_o (all_sent)
    );

    lsx_tx_stuffer #(.RUN_LIMIT(RUN_LIMIT)) u_stuff (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (stuff_clr),
        .adv_i       (stuff_adv),
        .bit_i       (cur_bit),
        .stuff_now_o (stuff_now),
        .run_o       (run_cnt)
    );

    lsx_tx_line u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (line_cmd),
        .oe_set_i (oe_set),
        .oe_clr_i (oe_clr),
        .dp_o     (dp_o),
        .dm_o     (dm_o),
        .oe_o     (oe_o)
    );

    assign busy_o = (ctl_q.st != ST_IDLE);
    assign done_o = ctl_q.done;

endmodule

// File: rtl/lsx_pkt_tx_chk.sv
module lsx_pkt_tx_chk #(
    parameter int RUN_LIMIT = 6,
    parameter int RUN_W     = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             bit_en_i,
    input logic             dp_o,
    input logic             dm_o,
    input logic             oe_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [RUN_W-1:0] run_q
);

    AST_START_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (oe_o && !dp_o && dm_o)); // R1

    AST_NO_SE1: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp_o && dm_o)); // R3

    AST_STUFF_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && bit_en_i && run_q == RUN_W'(RUN_LIMIT))
            |=> (dp_o != $past(dp_o) && dm_o != $past(dm_o))); // R4

    AST_SE0_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!dp_o && !dm_o) |-> oe_o); // R5

    AST_OE_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o == busy_o); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!oe_o && !busy_o)); // R7

    AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !bit_en_i) |=> ($stable(dp_o) && $stable(dm_o) && $stable(oe_o))); // R8

endmodule

bind lsx_pkt_tx lsx_pkt_tx_chk #(.RUN_LIMIT(RUN_LIMIT), .RUN_W(RUN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .bit_en_i (bit_en_i),
    .dp_o     (dp_o),
    .dm_o     (dm_o),
    .oe_o     (oe_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .run_q    (run_cnt)
);

// File: tb/lsx_pkt_tx_tb.sv
module lsx_pkt_tx_tb;

    localparam int NVEC = 7;
    // {count, byte0, byte1, byte2, byte3, expected stuffed bits}
    localparam logic [47:0] VEC [0:NVEC-1] = '{
        {8'd1, 8'hD2, 8'h00, 8'h00, 8'h00, 8'd0},  // one-byte handshake
        {8'd1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'd1},  // run starts in sync byte
        {8'd3, 8'hC3, 8'hFF, 8'hFF, 8'h00, 8'd3},  // stuff after final bit
        {8'd2, 8'h00, 8'h7E, 8'h00, 8'h00, 8'd1},  // exactly six ones
        {8'd2, 8'h00, 8'h1F, 8'h00, 8'h00, 8'd0},  // five ones only
        {8'd4, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'd5},  // long run across bytes
        {8'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'd0}   // sync only
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] nbytes = '0;
    logic [3:0] rd_addr;
    logic [7:0] rd_data;
    logic       bit_en = 1'b0;
    logic       tick_seen = 1'b0;
    logic [1:0] divc = '0;
    logic       dp, dm, oe, busy, done;
    logic [7:0] mem [0:15];
    int         n_checks = 0;
    int         n_err = 0;
    int         cyc = 0;

    always #4 clk = ~clk;

    assign rd_data = mem[rd_addr];

    always @(negedge clk) begin
        divc   <= divc + 2'd1;
        bit_en <= (divc == 2'd2);
    end

    always @(posedge clk) tick_seen <= bit_en;

    lsx_pkt_tx u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .nbytes_i  (nbytes),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data),
        .bit_en_i  (bit_en),
        .dp_o      (dp),
        .dm_o      (dm),
        .oe_o      (oe),
        .busy_o    (busy),
        .done_o    (done)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_pkt(input logic [47:0] v, input bit poke);
        logic [1:0] lines [0:399];
        logic       oes   [0:399];
        logic       dones [0:399];
        logic       bits  [0:255];
        logic [2:0] last;
        logic [1:0] prevl;
        int n, nt, nb, idx, run, stf, stab_err, enc_err, run_err, early_done;
        bit fin;
        logic raw;
        logic [7:0] by;
        n = int'(v[47:40]);
        mem[0] = v[39:32]; mem[1] = v[31:24]; mem[2] = v[23:16]; mem[3] = v[15:8];
        nt = 0; fin = 0; stab_err = 0; enc_err = 0; run_err = 0; early_done = 0;
        @(negedge clk);
        nbytes = 4'(n);
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        // R1: bus taken in J one cycle after the strobe
        chk(oe && !dp && dm && busy, "R1 takeover", {busy, oe, dp, dm}, 4'b1101);
        last = {dp, dm, oe};
        for (int c = 0; c < 4000 && !fin; c++) begin
            @(negedge clk);
            if (poke && c == 20) begin
                start  = 1'b1;
                nbytes = 4'd7;
            end else begin
                start = 1'b0;
            end
            if (tick_seen) begin
                lines[nt] = {dp, dm};
                oes[nt]   = oe;
                dones[nt] = done;
                nt++;
                if (!oe) fin = 1;
            end else if ({dp, dm, oe} != last) begin
                stab_err++;
            end
            last = {dp, dm, oe};
        end
        start = 1'b0;
        chk(stab_err == 0, "R8 hold between ticks", stab_err, 0);
        // decode NRZI and strip stuffed bits
        idx = 0; nb = 0; run = 0; stf = 0; prevl = 2'b01;
        while (idx < nt && lines[idx] != 2'b00) begin
            if (lines[idx] != 2'b01 && lines[idx] != 2'b10) enc_err++;
            if (!oes[idx]) enc_err++;
            raw   = (lines[idx] == prevl);
            prevl = lines[idx];
            if (run == 6) begin
                if (raw) run_err++;
                else stf++;
                run = 0;
            end else begin
                bits[nb] = raw;
                nb++;
                run = raw ? run + 1 : 0;
            end
            idx++;
        end
        chk(enc_err == 0, "R3 J/K only while sending", enc_err, 0);
        chk(run_err == 0, "R4 no run beyond six", run_err, 0);
        chk(stf == int'(v[7:0]), "R4 stuffed bit count", stf, int'(v[7:0]));
        chk(nb == 8 * (n + 1), "R2 bit count (R11 for zero)", nb, 8 * (n + 1));
        by = '0;
        for (int b = 0; b < 8; b++) by[b] = bits[b];
        chk(by == 8'h80, "R2 sync byte", by, 8'h80);
        for (int k = 0; k < n && nb == 8 * (n + 1); k++) begin
            for (int b = 0; b < 8; b++) by[b] = bits[8 * (k + 1) + b];
            chk(by == mem[k], "R3 payload byte", by, mem[k]);
        end
        chk(idx + 1 < nt && lines[idx] == 2'b00 && lines[idx+1] == 2'b00
            && oes[idx] && oes[idx+1], "R5 two SE0 bits", nt - idx, 4);
        chk(idx + 3 < nt && lines[idx+2] == 2'b01 && oes[idx+2] && !oes[idx+3]
            && nt == idx + 4, "R6 J then release", nt - idx, 4);
        for (int i = 0; i < nt - 1; i++) if (dones[i]) early_done++;
        chk(nt > 0 && dones[nt-1] && !busy && early_done == 0,
            "R7 done at release", {early_done[3:0], dones[nt-1], busy}, 6'b000010);
        @(negedge clk);
        chk(!done, "R7 done one cycle", done, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!oe && !busy && !done && !dp && dm, "R10 reset", {oe, busy, done, dp, dm}, 5'b00001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!oe && !busy && !done && !dp && dm, "R10 after reset", {oe, busy, done, dp, dm}, 5'b00001);
        for (int v = 0; v < NVEC; v++) begin
            run_pkt(VEC[v], 1'b0);
        end
        // R9: strobe and new count in flight are ignored
        run_pkt(VEC[2], 1'b1);
        run_pkt(VEC[0], 1'b1);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule